// File: doc/BRIEF.md
# Ordered Dispatch and Retirement Controller

This block sits between a queue of already-decoded instructions and the out-of-order schedulers. Each cycle it looks at the oldest few instructions, which the queue presents in program order. It forms a dispatch group from the longest leading run of them that fits every limit at once: the group's micro-op budget, free reorder-buffer entries, free physical registers for renaming, scheduler space, and load or store queue space. Instructions that are not dispatched stay in the queue. The queue removes as many instructions as the block reports dispatched.

Each dispatched instruction takes one reorder-buffer entry per micro-op. It is named by the index of its first entry, and that tag is returned on a completion port once execution finishes. Completed instructions leave the reorder buffer strictly in program order. On retirement their reorder-buffer entries and their destination register go back to the free pools.

The block keeps performance counters. Every cycle in which dispatch stops short because of a resource is charged to exactly one named cause. Histograms record micro-ops dispatched per cycle and instructions retired per cycle. Further counters record peak reorder-buffer occupancy, the running sum of occupancy and the cycle count, so the average occupancy is the sum divided by the cycle count.

Top module: `dispatch_retire_ctl`

## Requirements
- R1: Only a leading run of the valid window slots is dispatched in a cycle, so a slot is taken only if every older slot is taken. `dispValid` is combinational in the same cycle, and the queue pops that many entries.
- R2: A group carries at most DISP_W micro-ops in total. Each instruction has 1 to DISP_W micro-ops. An instruction that would exceed the budget waits, and that cycle is not charged as a stall.
- R3: An instruction needs as many free reorder-buffer entries as it has micro-ops, where free is ROB_DEPTH minus `robUsed`. `dispTag` gives the index of its first entry. Entries are handed out consecutively and wrap modulo ROB_DEPTH.
- R4: An instruction with `inDst` set needs one free physical register, and `regFree` counts the free registers. PRF_SIZE of 0 makes the register supply unbounded; in that case registers never block dispatch and `regFree` reads 0.
- R5: The micro-ops of a group must not exceed `schedFree`. Kind code 1 (load) needs one `lqFree` entry and kind code 2 (store) needs one `sqFree` entry. Codes 0 and 3 need neither.
- R6: An instruction with `inSolo` set is dispatched only as the first member of a group, and nothing joins a group after it.
- R7: When the first undispatched valid instruction fits the micro-op budget but is blocked, exactly one counter in `stallCnt` is incremented. The first blocking cause in this order is charged: index 0 reorder buffer, 1 registers, 2 scheduler, 3 load queue, 4 store queue, 5 solo rule.
- R8: Up to DISP_W instructions retire per cycle, oldest first, and retirement stops at the first instruction not yet completed. A completion given on `cmplTag` makes the instruction eligible from the next cycle, and `retireCnt` is combinational.
- R9: Entries and registers released by retirement are available for dispatch from the next cycle.
- R10: Each cycle out of reset increments `dispHist[n]`, where n is the number of micro-ops dispatched, and `retHist[m]`, where m is the number of instructions retired.
- R11: `robMax` holds the largest `robUsed` seen so far. `robSum` accumulates `robUsed` every cycle and `cycleCnt` counts cycles out of reset.
- R12: After reset the reorder buffer is empty, `regFree` equals PRF_SIZE and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | DISP_W | Window slot holds an instruction (leading run) |
| inUops | input | DISP_W x UW | Micro-op count per slot |
| inDst | input | DISP_W | Slot writes a register that needs renaming |
| inKind | input | DISP_W x 2 | 0 arithmetic, 1 load, 2 store, 3 other |
| inSolo | input | DISP_W | Slot must dispatch alone at group start |
| schedFree | input | QW | Free scheduler entries |
| lqFree | input | QW | Free load queue entries |
| sqFree | input | QW | Free store queue entries |
| cmplValid | input | 1 | An instruction finished executing |
| cmplTag | input | IW | Tag of the finished instruction |
| dispValid | output | DISP_W | Slot dispatched this cycle |
| dispTag | output | DISP_W x IW | Reorder-buffer tag per dispatched slot |
| retireCnt | output | UW | Instructions retired this cycle |
| robUsed | output | OW | Occupied reorder-buffer entries |
| regFree | output | RW | Free physical registers |
| stallCnt | output | 6 x CW | Stall cycles per cause |
| dispHist | output | (DISP_W+1) x CW | Cycles by micro-ops dispatched |
| retHist | output | (DISP_W+1) x CW | Cycles by instructions retired |
| robMax | output | OW | Peak occupancy |
| robSum | output | CW+OW | Occupancy summed over cycles |
| cycleCnt | output | CW | Cycles since reset |

## Verification
A leak in the occupancy count or in the free-register count shows up one cycle later on `robUsed` or `regFree`. Within a few cycles it also appears as a dispatch that is wrongly granted or wrongly refused, and a stall charged to the wrong cause. A lost completion or a wrong head pointer stops `retireCnt` at the oldest instruction, and the reorder buffer then fills. A corrupted entry shows as a wrong `dispTag` in the same cycle, or as a wrong number of entries or registers released when that instruction retires. Counter and histogram faults are cumulative and are compared in full once the run ends.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    KIND_ALU   = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_OTHER = 2'd3
  } kind_e;

  localparam int NCAUSE  = 6;
  localparam int C_ROB   = 0;
  localparam int C_REG   = 1;
  localparam int C_SCHED = 2;
  localparam int C_LQ    = 3;
  localparam int C_SQ    = 4;
  localparam int C_GROUP = 5;
  localparam int MAXW    = 8;  // upper bound on dispatch width

  typedef struct packed {
    logic [MAXW-1:0]   takeMask;
    logic [7:0]        allocUops;
    logic [7:0]        allocRegs;
    logic [NCAUSE-1:0] stallVec;
  } ctrl_strobe_t;
endpackage

// File: rtl/drc_dispatch_ctrl.sv
module drc_dispatch_ctrl
  import drc_pkg::*;
#(
  parameter int DISP_W   = 2,
  parameter int PRF_SIZE = 8,
  parameter int UW       = 2,
  parameter int QW       = 4,
  parameter int OW       = 5,
  parameter int RW       = 4
) (
  input  logic [DISP_W-1:0]         inValid,
  input  logic [DISP_W-1:0][UW-1:0] inUops,
  input  logic [DISP_W-1:0]         inDst,
  input  logic [DISP_W-1:0][1:0]    inKind,
  input  logic [DISP_W-1:0]         inSolo,
  input  logic [QW-1:0]             schedFree,
  input  logic [QW-1:0]             lqFree,
  input  logic [QW-1:0]             sqFree,
  input  logic [OW-1:0]             robFree,
  input  logic [RW-1:0]             regFree,
  output ctrl_strobe_t              strobe
);
  always_comb begin
    int   cumU, cumR, cumL, cumS, needU, needR, needL, needS;
    logic scanning, prevSolo;
    logic bRob, bReg, bSch, bLq, bSq, bGrp;
    strobe   = '0;
    cumU     = 0;
    cumR     = 0;
    cumL     = 0;
    cumS     = 0;
    scanning = 1'b1;
    prevSolo = 1'b0;
    for (int k = 0; k < DISP_W; k++) begin
      needU = cumU + int'(inUops[k]);
      needR = cumR + (inDst[k] ? 1 : 0);
      needL = cumL + ((inKind[k] == KIND_LOAD) ? 1 : 0);
      needS = cumS + ((inKind[k] == KIND_STORE) ? 1 : 0);
      bRob  = needU > int'(robFree);
      bReg  = (PRF_SIZE != 0) && (needR > int'(regFree));
      bSch  = needU > int'(schedFree);
      bLq   = needL > int'(lqFree);
      bSq   = needS > int'(sqFree);
      bGrp  = (k != 0) && (inSolo[k] || prevSolo);
      if (scanning) begin
        if (!inValid[k] || needU > DISP_W) begin
          scanning = 1'b0;            // empty slot or full group: no charge
        end else if (bRob || bReg || bSch || bLq || bSq || bGrp) begin
          scanning = 1'b0;
          if (bRob)      strobe.stallVec[C_ROB]   = 1'b1;
          else if (bReg) strobe.stallVec[C_REG]   = 1'b1;
          else if (bSch) strobe.stallVec[C_SCHED] = 1'b1;
          else if (bLq)  strobe.stallVec[C_LQ]    = 1'b1;
          else if (bSq)  strobe.stallVec[C_SQ]    = 1'b1;
          else           strobe.stallVec[C_GROUP] = 1'b1;
        end else begin
          strobe.takeMask[k] = 1'b1;
          cumU     = needU;
          cumR     = needR;
          cumL     = needL;
          cumS     = needS;
          prevSolo = inSolo[k];
        end
      end
    end
    strobe.allocUops = 8'(cumU);
    strobe.allocRegs = 8'(cumR);
  end
endmodule

// File: rtl/drc_rob_datapath.sv
module drc_rob_datapath
  import drc_pkg::*;
#(
  parameter int DISP_W    = 2,
  parameter int ROB_DEPTH = 16,
  parameter int PRF_SIZE  = 8,
  parameter int UW        = 2,
  parameter int IW        = 4,
  parameter int OW        = 5,
  parameter int RW        = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              strobe,
  input  logic [DISP_W-1:0][UW-1:0] inUops,
  input  logic [DISP_W-1:0]         inDst,
  input  logic                      cmplValid,
  input  logic [IW-1:0]             cmplTag,
  output logic [DISP_W-1:0][IW-1:0] dispTag,
  output logic [OW-1:0]             robUsed,
  output logic [OW-1:0]             robFree,
  output logic [RW-1:0]             regFree,
  output logic [UW-1:0]             retireCnt
);
  logic [ROB_DEPTH-1:0][UW-1:0] entUops;
  logic [ROB_DEPTH-1:0]         entDst;
  logic [ROB_DEPTH-1:0]         entDone;
  logic [IW-1:0]                head, tail;
  logic [OW-1:0]                occ;
  logic [DISP_W-1:0][IW-1:0]    slotIdx;
  logic [OW-1:0]                retUops;
  logic [RW-1:0]                retRegs;

  always_comb begin
    int off;
    off = 0;
    for (int k = 0; k < DISP_W; k++) begin
      slotIdx[k] = tail + IW'(off);
      if (strobe.takeMask[k]) off = off + int'(inUops[k]);
    end
  end
  assign dispTag = slotIdx;

  // in-order retirement walk from the head
  always_comb begin
    int cum, regs, n;
    logic go;
    logic [IW-1:0] pos;
    cum = 0;
    regs = 0;
    n = 0;
    go = 1'b1;
    pos = head;
    for (int k = 0; k < DISP_W; k++) begin
      if (go && cum < int'(occ) && entDone[pos]) begin
        n    = n + 1;
        cum  = cum + int'(entUops[pos]);
        regs = regs + (entDst[pos] ? 1 : 0);
        pos  = head + IW'(cum);
      end else begin
        go = 1'b0;
      end
    end
    retireCnt = UW'(n);
    retUops   = OW'(cum);
    retRegs   = RW'(regs);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head    <= '0;
      tail    <= '0;
      occ     <= '0;
      entUops <= '0;
      entDst  <= '0;
      entDone <= '0;
    end else begin
      head <= head + IW'(retUops);
      tail <= tail + IW'(strobe.allocUops);
      occ  <= occ + OW'(strobe.allocUops) - retUops;
      if (cmplValid) entDone[cmplTag] <= 1'b1;
      for (int k = 0; k < DISP_W; k++) begin
        if (strobe.takeMask[k]) begin
          entUops[slotIdx[k]] <= inUops[k];
          entDst[slotIdx[k]]  <= inDst[k];
          entDone[slotIdx[k]] <= 1'b0;
        end
      end
    end
  end

  assign robUsed = occ;
  assign robFree = OW'(ROB_DEPTH) - occ;

  generate
    if (PRF_SIZE == 0) begin : g_unbounded
      assign regFree = '0;
    end else begin : g_bounded
      logic [RW-1:0] regFreeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFreeQ <= RW'(PRF_SIZE);
        else       regFreeQ <= regFreeQ - RW'(strobe.allocRegs) + retRegs;
      end
      assign regFree = regFreeQ;
      a_r4_reg_bound: assert property (@(posedge clk) disable iff (!rstN)
        regFreeQ <= RW'(PRF_SIZE));
    end
  endgenerate

  logic unusedBits;
  assign unusedBits = ^{strobe.stallVec, strobe.takeMask, strobe.allocRegs, retRegs};

  a_r3_rob_bound: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OW'(ROB_DEPTH));
  a_r8_retire_in_occ: assert property (@(posedge clk) disable iff (!rstN)
    retUops <= occ);
endmodule

// File: rtl/drc_stats.sv
module drc_stats
  import drc_pkg::*;
#(
  parameter int DISP_W = 2,
  parameter int UW     = 2,
  parameter int OW     = 5,
  parameter int CW     = 32,
  parameter int SW     = 37
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strobe,
  input  logic [UW-1:0]              retireCnt,
  input  logic [OW-1:0]              robUsed,
  output logic [NCAUSE-1:0][CW-1:0]  stallCnt,
  output logic [DISP_W:0][CW-1:0]    dispHist,
  output logic [DISP_W:0][CW-1:0]    retHist,
  output logic [OW-1:0]              robMax,
  output logic [SW-1:0]              robSum,
  output logic [CW-1:0]              cycleCnt
);
  genvar g;
  generate
    for (g = 0; g < NCAUSE; g++) begin : g_cause
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   stallCnt[g] <= '0;
        else if (strobe.stallVec[g]) stallCnt[g] <= stallCnt[g] + CW'(1);
      end
    end
    for (g = 0; g <= DISP_W; g++) begin : g_bin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dispHist[g] <= '0;
          retHist[g]  <= '0;
        end else begin
          if (int'(strobe.allocUops) == g) dispHist[g] <= dispHist[g] + CW'(1);
          if (int'(retireCnt) == g)        retHist[g]  <= retHist[g] + CW'(1);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      robMax   <= '0;
      robSum   <= '0;
      cycleCnt <= '0;
    end else begin
      if (robUsed > robMax) robMax <= robUsed;
      robSum   <= robSum + SW'(robUsed);
      cycleCnt <= cycleCnt + CW'(1);
    end
  end

  logic unusedStats;
  assign unusedStats = ^{strobe.takeMask, strobe.allocRegs};

  a_r7_one_cause: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.stallVec));
  a_r2_width: assert property (@(posedge clk) disable iff (!rstN)
    int'(strobe.allocUops) <= DISP_W);
  a_r11_max_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> robMax >= $past(robUsed));
endmodule

// File: rtl/dispatch_retire_ctl.sv
module dispatch_retire_ctl
  import drc_pkg::*;
#(
  parameter  int DISP_W    = 2,
  parameter  int ROB_DEPTH = 16,
  parameter  int PRF_SIZE  = 8,
  parameter  int QW        = 4,
  parameter  int CW        = 32,
  localparam int UW        = $clog2(DISP_W + 1),
  localparam int IW        = $clog2(ROB_DEPTH),
  localparam int OW        = $clog2(ROB_DEPTH + 1),
  localparam int RW        = (PRF_SIZE == 0) ? 1 : $clog2(PRF_SIZE + 1),
  localparam int SW        = CW + OW
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DISP_W-1:0]          inValid,
  input  logic [DISP_W-1:0][UW-1:0]  inUops,
  input  logic [DISP_W-1:0]          inDst,
  input  logic [DISP_W-1:0][1:0]     inKind,
  input  logic [DISP_W-1:0]          inSolo,
  input  logic [QW-1:0]              schedFree,
  input  logic [QW-1:0]              lqFree,
  input  logic [QW-1:0]              sqFree,
  input  logic                       cmplValid,
  input  logic [IW-1:0]              cmplTag,
  output logic [DISP_W-1:0]          dispValid,
  output logic [DISP_W-1:0][IW-1:0]  dispTag,
  output logic [UW-1:0]              retireCnt,
  output logic [OW-1:0]              robUsed,
  output logic [RW-1:0]              regFree,
  output logic [NCAUSE-1:0][CW-1:0]  stallCnt,
  output logic [DISP_W:0][CW-1:0]    dispHist,
  output logic [DISP_W:0][CW-1:0]    retHist,
  output logic [OW-1:0]              robMax,
  output logic [SW-1:0]              robSum,
  output logic [CW-1:0]              cycleCnt
);
  ctrl_strobe_t  strobe;
  logic [OW-1:0] robFree;

  drc_dispatch_ctrl #(
    .DISP_W(DISP_W), .PRF_SIZE(PRF_SIZE), .UW(UW), .QW(QW), .OW(OW), .RW(RW)
  ) ctrl_i (
    .inValid(inValid), .inUops(inUops), .inDst(inDst), .inKind(inKind),
    .inSolo(inSolo), .schedFree(schedFree), .lqFree(lqFree), .sqFree(sqFree),
    .robFree(robFree), .regFree(regFree), .strobe(strobe)
  );

  drc_rob_datapath #(
    .DISP_W(DISP_W), .ROB_DEPTH(ROB_DEPTH), .PRF_SIZE(PRF_SIZE),
    .UW(UW), .IW(IW), .OW(OW), .RW(RW)
  ) rob_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inUops(inUops), .inDst(inDst),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .dispTag(dispTag),
    .robUsed(robUsed), .robFree(robFree), .regFree(regFree),
    .retireCnt(retireCnt)
  );

  drc_stats #(
    .DISP_W(DISP_W), .UW(UW), .OW(OW), .CW(CW), .SW(SW)
  ) stats_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .retireCnt(retireCnt),
    .robUsed(robUsed), .stallCnt(stallCnt), .dispHist(dispHist),
    .retHist(retHist), .robMax(robMax), .robSum(robSum), .cycleCnt(cycleCnt)
  );

  assign dispValid = strobe.takeMask[DISP_W-1:0];
endmodule

// File: tb/dispatch_retire_ctl_tb_top.sv
module dispatch_retire_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 2;
  localparam int RD  = 16;
  localparam int PRF = 8;
  localparam int QW  = 4;
  localparam int CW  = 32;
  localparam int UW  = 2;
  localparam int IW  = 4;
  localparam int OW  = 5;
  localparam int RW  = 4;
  localparam int NCYC = 6000;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0]          inValid, inDst, inSolo;
  logic [DW-1:0][UW-1:0]  inUops;
  logic [DW-1:0][1:0]     inKind;
  logic [QW-1:0]          schedFree, lqFree, sqFree;
  logic                   cmplValid;
  logic [IW-1:0]          cmplTag;
  logic [DW-1:0]          dispValid;
  logic [DW-1:0][IW-1:0]  dispTag;
  logic [UW-1:0]          retireCnt;
  logic [OW-1:0]          robUsed;
  logic [RW-1:0]          regFree;
  logic [5:0][CW-1:0]     stallCnt;
  logic [DW:0][CW-1:0]    dispHist, retHist;
  logic [OW-1:0]          robMax;
  logic [CW+OW-1:0]       robSum;
  logic [CW-1:0]          cycleCnt;

  dispatch_retire_ctl #(.DISP_W(DW), .ROB_DEPTH(RD), .PRF_SIZE(PRF), .QW(QW), .CW(CW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inUops(inUops), .inDst(inDst),
    .inKind(inKind), .inSolo(inSolo), .schedFree(schedFree), .lqFree(lqFree),
    .sqFree(sqFree), .cmplValid(cmplValid), .cmplTag(cmplTag),
    .dispValid(dispValid), .dispTag(dispTag), .retireCnt(retireCnt),
    .robUsed(robUsed), .regFree(regFree), .stallCnt(stallCnt),
    .dispHist(dispHist), .retHist(retHist), .robMax(robMax), .robSum(robSum),
    .cycleCnt(cycleCnt)
  );

  // second instance: unbounded rename registers, fixed stream, no completions
  logic [DW-1:0]          uDispValid;
  logic [DW-1:0][IW-1:0]  uDispTag;
  logic [UW-1:0]          uRetireCnt;
  logic [OW-1:0]          uRobUsed;
  logic                   uRegFree;
  logic [5:0][CW-1:0]     uStallCnt;
  logic [DW:0][CW-1:0]    uDispHist, uRetHist;
  logic [OW-1:0]          uRobMax;
  logic [CW+OW-1:0]       uRobSum;
  logic [CW-1:0]          uCycleCnt;

  dispatch_retire_ctl #(.DISP_W(DW), .ROB_DEPTH(RD), .PRF_SIZE(0), .QW(QW), .CW(CW)) dutU_i (
    .clk(clk), .rstN(rstN), .inValid(2'b11), .inUops({2'd1, 2'd1}), .inDst(2'b11),
    .inKind({2'd0, 2'd0}), .inSolo(2'b00), .schedFree(4'd15), .lqFree(4'd15),
    .sqFree(4'd15), .cmplValid(1'b0), .cmplTag(4'd0),
    .dispValid(uDispValid), .dispTag(uDispTag), .retireCnt(uRetireCnt),
    .robUsed(uRobUsed), .regFree(uRegFree), .stallCnt(uStallCnt),
    .dispHist(uDispHist), .retHist(uRetHist), .robMax(uRobMax), .robSum(uRobSum),
    .cycleCnt(uCycleCnt)
  );

  typedef struct { int uops; int dst; int kind; int solo; } ins_t;
  typedef struct { int tag; int uops; int dst; bit done; } rec_t;
  ins_t iq[$];
  rec_t fl[$];

  int errors = 0, checks = 0;
  bit finished = 0;
  int mOcc, mRegFree, mTail;
  int eStall[6], eDisp[DW+1], eRet[DW+1];
  longint eSum;
  int eMax, eCyc;
  int curSched, curLq, curSq;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic ins_t new_ins(int soloPct);
    ins_t n;
    n.uops = 1 + int'($urandom % 2);
    n.dst  = ($urandom % 4 != 0) ? 1 : 0;
    n.kind = int'($urandom % 4);
    n.solo = (int'($urandom % 100) < soloPct) ? 1 : 0;
    return n;
  endfunction

  // expected group per the requirements: count taken, stall cause, uops
  task automatic exp_disp(output int take, output int cause, output int sumU);
    int cu, cr, cl, cs, sPrev;
    bit stopped;
    take = 0; cause = -1; cu = 0; cr = 0; cl = 0; cs = 0; sPrev = 0; stopped = 0;
    for (int k = 0; k < DW; k++) begin
      if (!stopped) begin
        if (k >= iq.size()) stopped = 1;
        else if (cu + iq[k].uops > DW) stopped = 1;
        else begin
          int c;
          c = -1;
          if (cu + iq[k].uops > RD - mOcc) c = 0;
          else if (cr + iq[k].dst > mRegFree) c = 1;
          else if (cu + iq[k].uops > curSched) c = 2;
          else if (iq[k].kind == 1 && cl + 1 > curLq) c = 3;
          else if (iq[k].kind == 2 && cs + 1 > curSq) c = 4;
          else if (k > 0 && (iq[k].solo != 0 || sPrev != 0)) c = 5;
          if (c >= 0) begin cause = c; stopped = 1; end
          else begin
            take++; cu += iq[k].uops; cr += iq[k].dst;
            if (iq[k].kind == 1) cl++;
            if (iq[k].kind == 2) cs++;
            sPrev = iq[k].solo;
          end
        end
      end
    end
    sumU = cu;
  endtask

  task automatic step(int phase);
    int take, cause, sumU, pick, eR, off;
    bit refill;
    int soloPct, cmplPct;
    refill  = (phase != 2);
    soloPct = (phase == 3) ? 40 : 5;
    cmplPct = (phase == 1) ? 0 : ((phase == 2) ? 90 : 45);
    while (refill && iq.size() < 4 && ($urandom % 4 != 0)) iq.push_back(new_ins(soloPct));
    curSched = (phase == 0 || phase == 3) ? int'($urandom % 16) :
               (phase == 4) ? int'($urandom % 3) : 15;
    curLq = (phase == 4) ? int'($urandom % 2) : int'($urandom % 4);
    curSq = (phase == 4) ? int'($urandom % 2) : int'($urandom % 4);
    if (phase == 1 || phase == 2) begin curLq = 15; curSq = 15; end
    for (int k = 0; k < DW; k++) begin
      inValid[k] = (k < iq.size());
      inUops[k]  = (k < iq.size()) ? UW'(iq[k].uops) : '0;
      inDst[k]   = (k < iq.size()) ? (iq[k].dst != 0) : 1'b0;
      inKind[k]  = (k < iq.size()) ? 2'(iq[k].kind) : 2'd0;
      inSolo[k]  = (k < iq.size()) ? (iq[k].solo != 0) : 1'b0;
    end
    schedFree = QW'(curSched);
    lqFree = QW'(curLq);
    sqFree = QW'(curSq);
    cmplValid = 1'b0;
    cmplTag = '0;
    pick = -1;
    if (fl.size() > 0 && int'($urandom % 100) < cmplPct) begin
      int i;
      i = int'($urandom % fl.size());
      if (!fl[i].done) begin
        cmplValid = 1'b1; cmplTag = IW'(fl[i].tag); pick = i;
      end
    end
    #1;
    exp_disp(take, cause, sumU);
    eR = 0;
    for (int i = 0; i < fl.size() && eR < DW; i++) begin
      if (fl[i].done) eR++;
      else break;
    end
    // R1, R2, R5, R6: which slots are taken
    chk("R1 dispValid", longint'(dispValid), longint'((1 << take) - 1));
    off = 0;
    for (int k = 0; k < take; k++) begin
      chk("R3 dispTag", longint'(dispTag[k]), longint'((mTail + off) % RD));
      off += iq[k].uops;
    end
    chk("R8 retireCnt", longint'(retireCnt), longint'(eR));
    chk("R3 robUsed", longint'(robUsed), longint'(mOcc));
    chk("R9 regFree", longint'(regFree), longint'(mRegFree));
    eDisp[sumU]++;
    eRet[eR]++;
    if (cause >= 0) eStall[cause]++;
    eSum += mOcc;
    if (mOcc > eMax) eMax = mOcc;
    eCyc++;
    @(posedge clk);
    if (pick >= 0) fl[pick].done = 1;
    for (int i = 0; i < eR; i++) begin
      rec_t r;
      r = fl.pop_front();
      mOcc -= r.uops;
      mRegFree += r.dst;
    end
    for (int k = 0; k < take; k++) begin
      rec_t r;
      ins_t n;
      n = iq.pop_front();
      r.tag = mTail; r.uops = n.uops; r.dst = n.dst; r.done = 0;
      fl.push_back(r);
      mTail = (mTail + n.uops) % RD;
      mOcc += n.uops;
      mRegFree -= n.dst;
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    inValid = '0; inUops = '0; inDst = '0; inKind = '0; inSolo = '0;
    schedFree = '0; lqFree = '0; sqFree = '0; cmplValid = 1'b0; cmplTag = '0;
    mOcc = 0; mRegFree = PRF; mTail = 0; eSum = 0; eMax = 0; eCyc = 0;
    foreach (eStall[i]) eStall[i] = 0;
    for (int i = 0; i <= DW; i++) begin eDisp[i] = 0; eRet[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk("R12 robUsed", longint'(robUsed), 0);
    chk("R12 regFree", longint'(regFree), PRF);
    chk("R12 retireCnt", longint'(retireCnt), 0);
    chk("R12 dispValid", longint'(dispValid), 0);
    chk("R12 cycleCnt", longint'(cycleCnt), 0);
    chk("R12 stallCnt", longint'(stallCnt[0] | stallCnt[1] | stallCnt[5]), 0);
    rstN = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      int ph;
      ph = (c < 2000) ? 0 : (c < 2500) ? 1 : (c < 3000) ? 2 : (c < 4000) ? 3 : 4;
      step(ph);
      if (c == 2999) begin
        // after the drain phase everything has retired
        chk("R9 drained robUsed", longint'(robUsed), 0);
        chk("R9 drained regFree", longint'(regFree), PRF);
      end
    end
    // R7, R10, R11: accumulated counters
    for (int i = 0; i < 6; i++) chk("R7 stallCnt", longint'(stallCnt[i]), longint'(eStall[i]));
    for (int i = 0; i <= DW; i++) begin
      chk("R10 dispHist", longint'(dispHist[i]), longint'(eDisp[i]));
      chk("R10 retHist", longint'(retHist[i]), longint'(eRet[i]));
    end
    chk("R11 robMax", longint'(robMax), longint'(eMax));
    chk("R11 robSum", longint'(robSum), eSum);
    chk("R11 cycleCnt", longint'(cycleCnt), longint'(eCyc));
    chk("R4 stall charged to ROB and registers seen", longint'(eStall[0] > 0 && eStall[1] > 0), 1);
    // R4: unbounded registers never block, the reorder buffer does
    chk("R4 unbounded reg stalls", longint'(uStallCnt[1]), 0);
    chk("R4 unbounded rob stalls", longint'(uStallCnt[0]), longint'(eCyc - 8));
    chk("R4 unbounded robUsed", longint'(uRobUsed), RD);
    chk("R4 unbounded regFree", longint'(uRegFree), 0);
    chk("R2 unbounded full groups", longint'(uDispHist[2]), 8);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule